// File: doc/BRIEF.md
# Fixed System Clock Strobe Divider Chain

This block turns a per-cycle core clock enable into four derived clock enables for the fixed system clocks: the system bus clock, the peripheral clock, the memory clock and the external static bus clock. All four are single-cycle strobes in the same clock domain. Each one is produced by a divider that counts strobes of its parent clock. The bus clock counts core enables. The peripheral and memory clocks count bus strobes. The static bus clock counts peripheral strobes. A derived strobe can therefore only fire in a cycle where its parent fires, and the whole tree stays phase-aligned.

The division ratios are decoded from three configuration words and a two-bit variant code. The decode is done once, on the first clock after reset is released, and the result is then frozen. The configuration acts as read-only for the rest of the run. The variant code picks where the memory divide bit lives and which static bus clock decode applies.

Top module: `sbc_divchain`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls (the capture cycle), all four strobe outputs are low.
- R2: After capture, `bus_stb` goes high one cycle after every Nth cycle with `core_en` high. N is `pwr_word[1:0] + 2`, and the count starts from zero at capture.
- R3: A `pwr_word[1:0]` value of 3 gives a bus ratio of 4, not 5.
- R4: `per_stb` fires on every second bus strobe. The first time is the second bus strobe after capture.
- R5: With `var_sel` = 2, the memory ratio is 1 if `mem_word[15]` is set and 2 otherwise. With `var_sel` = 3, the same choice is made by `mem_word[31]`, and bit 15 is ignored.
- R6: With `var_sel` = 0 or 1, the memory ratio is 2 whatever `mem_word` holds.
- R7: With `var_sel` = 0, `sta_stb` fires on every 5th peripheral strobe if `sta_word[11]` is set, and on every 4th otherwise.
- R8: With `var_sel` = 1, 2 or 3, `sta_stb` fires on every (`sta_word[15:13]` + 1)th peripheral strobe.
- R9: A change to `var_sel`, `pwr_word`, `mem_word` or `sta_word` after the capture cycle has no effect on any strobe until the next reset.
- R10: `per_stb` and `mem_stb` are high only together with `bus_stb`. `sta_stb` is high only together with `per_stb`. `bus_stb` is high only in the cycle after a cycle with `core_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_en | input | 1 | Core clock enable strobe |
| var_sel | input | 2 | Variant code (0..3) |
| pwr_word | input | REG_W | Power control word; bits [1:0] give the bus ratio |
| mem_word | input | REG_W | Memory configuration word; bit 15 or bit 31 selects the memory divide |
| sta_word | input | REG_W | Static bus configuration word; bit 11 or bits [15:13] give the static ratio |
| bus_stb | output | 1 | System bus clock strobe |
| per_stb | output | 1 | Peripheral clock strobe |
| mem_stb | output | 1 | Memory clock strobe |
| sta_stb | output | 1 | Static bus clock strobe |

## Verification
The assertions assume that `core_en` is a plain level sampled once per clock, with no constraint on how often it is high. They also assume that reset is held for at least one edge before each configuration is used, because the peripheral parity counter in the checker restarts only on reset. The stimulus holds reset for several cycles before each case. It then drives `core_en` either continuously high or as a random pattern, so that strobes land both back to back and with gaps. In one case every configuration input is inverted part way through a run, and the reference model keeps the ratios it captured.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int RW       = 4;   // ratio / counter width, holds ratios up to 8
  localparam int NSTG     = 4;   // number of derived clocks
  localparam int STG_BUS  = 0;
  localparam int STG_PER  = 1;
  localparam int STG_MEM  = 2;
  localparam int STG_STA  = 3;
  localparam int PER_RATIO = 2;

  // configuration field positions
  localparam int PWR_LSB     = 0;
  localparam int MEM_BIT_MID = 15;
  localparam int MEM_BIT_NEW = 31;
  localparam int STA_LEG_BIT = 11;
  localparam int STA_D_LSB   = 13;

  typedef enum logic [1:0] {
    VAR_OLD_A = 2'd0,
    VAR_OLD_B = 2'd1,
    VAR_MID   = 2'd2,
    VAR_NEW   = 2'd3
  } variant_e;

  typedef logic [RW-1:0] ratio_t;
endpackage

// File: rtl/sbc_ratio_latch.sv
module sbc_ratio_latch
  import sbc_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               var_sel,
  input  logic [REG_W-1:0]         pwr_word,
  input  logic [REG_W-1:0]         mem_word,
  input  logic [REG_W-1:0]         sta_word,
  output logic                     run,
  output logic [NSTG-1:0][RW-1:0]  rat
);
  logic [1:0] p_fld;
  ratio_t     d_bus, d_mem, d_sta;
  variant_e   vsel;

  assign vsel = variant_e'(var_sel);

  always_comb begin
    p_fld = pwr_word[PWR_LSB +: 2];
    // a field value of 3 would mean 5; clamp to the largest legal ratio
    d_bus = (p_fld == 2'd3) ? RW'(4) : (RW'(p_fld) + RW'(2));

    case (vsel)
      VAR_MID: d_mem = mem_word[MEM_BIT_MID] ? RW'(1) : RW'(2);
      VAR_NEW: d_mem = mem_word[MEM_BIT_NEW] ? RW'(1) : RW'(2);
      default: d_mem = RW'(2);
    endcase

    if (vsel == VAR_OLD_A)
      d_sta = sta_word[STA_LEG_BIT] ? RW'(5) : RW'(4);
    else
      d_sta = RW'(sta_word[STA_D_LSB +: 3]) + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      rat <= '0;
    end else if (!run) begin
      run          <= 1'b1;
      rat[STG_BUS] <= d_bus;
      rat[STG_PER] <= RW'(PER_RATIO);
      rat[STG_MEM] <= d_mem;
      rat[STG_STA] <= d_sta;
    end
  end
endmodule

// File: rtl/sbc_strobe_div.sv
module sbc_strobe_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         parent_en,
  input  logic [W-1:0] ratio,
  output logic         hit_stb
);
  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end  = (cnt == (ratio - W'(1)));
  assign hit_stb = run & parent_en & at_end;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (parent_en)
      cnt <= at_end ? '0 : (cnt + W'(1));
  end
endmodule

// File: rtl/sbc_divchain.sv
module sbc_divchain
  import sbc_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_en,
  input  logic [1:0]       var_sel,
  input  logic [REG_W-1:0] pwr_word,
  input  logic [REG_W-1:0] mem_word,
  input  logic [REG_W-1:0] sta_word,
  output logic             bus_stb,
  output logic             per_stb,
  output logic             mem_stb,
  output logic             sta_stb
);
  logic                    run;
  logic [NSTG-1:0][RW-1:0] rat;
  logic [NSTG-1:0]         par;
  logic [NSTG-1:0]         st;

  sbc_ratio_latch #(.REG_W(REG_W)) u_lat (
    .clk      (clk),
    .rst      (rst),
    .var_sel  (var_sel),
    .pwr_word (pwr_word),
    .mem_word (mem_word),
    .sta_word (sta_word),
    .run      (run),
    .rat      (rat)
  );

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    if (i == STG_BUS) begin : g_root
      assign par[i] = core_en;
    end else if (i == STG_STA) begin : g_leaf
      assign par[i] = st[STG_PER];
    end else begin : g_mid
      assign par[i] = st[STG_BUS];
    end

    sbc_strobe_div #(.W(RW)) u_div (
      .clk       (clk),
      .rst       (rst),
      .run       (run),
      .parent_en (par[i]),
      .ratio     (rat[i]),
      .hit_stb   (st[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_stb <= 1'b0;
      per_stb <= 1'b0;
      mem_stb <= 1'b0;
      sta_stb <= 1'b0;
    end else begin
      bus_stb <= st[STG_BUS];
      per_stb <= st[STG_PER];
      mem_stb <= st[STG_MEM];
      sta_stb <= st[STG_STA];
    end
  end
endmodule

// File: rtl/sbc_divchain_chk.sv
module sbc_divchain_chk (
  input logic clk,
  input logic rst,
  input logic core_en,
  input logic bus_stb,
  input logic per_stb,
  input logic mem_stb,
  input logic sta_stb
);
  logic par_cnt;

  // tracks bus strobes since the last peripheral strobe
  always_ff @(posedge clk) begin
    if (rst)
      par_cnt <= 1'b0;
    else if (bus_stb)
      par_cnt <= per_stb ? 1'b0 : 1'b1;
  end

  assert_per_on_bus_R10: assert property (@(posedge clk) disable iff (rst)
    per_stb |-> bus_stb);

  assert_mem_on_bus_R10: assert property (@(posedge clk) disable iff (rst)
    mem_stb |-> bus_stb);

  assert_sta_on_per_R10: assert property (@(posedge clk) disable iff (rst)
    sta_stb |-> per_stb);

  assert_bus_after_core_R10: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> $past(core_en));

  assert_per_every_second_R4: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> (per_stb == par_cnt));
endmodule

bind sbc_divchain sbc_divchain_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .core_en (core_en),
  .bus_stb (bus_stb),
  .per_stb (per_stb),
  .mem_stb (mem_stb),
  .sta_stb (sta_stb)
);

// File: tb/sim_sbc_divchain.sv
module sim_sbc_divchain;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst = 1'b1;
  logic        core_en = 1'b0;
  logic [1:0]  var_sel = 2'd0;
  logic [31:0] pwr_word = '0, mem_word = '0, sta_word = '0;
  logic        bus_stb, per_stb, mem_stb, sta_stb;

  sbc_divchain u0 (
    .clk(clk), .rst(rst), .core_en(core_en), .var_sel(var_sel),
    .pwr_word(pwr_word), .mem_word(mem_word), .sta_word(sta_word),
    .bus_stb(bus_stb), .per_stb(per_stb), .mem_stb(mem_stb), .sta_stb(sta_stb)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  string tg_bus = "R2", tg_per = "R4", tg_mem = "R6", tg_sta = "R7";

  // reference model state
  int phase = 0;                 // 0 reset, 1 capture, 2 running
  int r_bus, r_mem, r_sta;
  int c_bus, c_per, c_mem, c_sta;
  int e_bus, e_per, e_mem, e_sta;

  function automatic int dec_mem(input int v, input logic [31:0] w);
    if (v == 2) return w[15] ? 1 : 2;
    if (v == 3) return w[31] ? 1 : 2;
    return 2;
  endfunction

  function automatic int dec_sta(input int v, input logic [31:0] w);
    if (v == 0) return w[11] ? 5 : 4;
    return int'(w[15:13]) + 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      phase = 0;
      c_bus = 0; c_per = 0; c_mem = 0; c_sta = 0;
      e_bus = 0; e_per = 0; e_mem = 0; e_sta = 0;
    end else if (phase == 0) begin
      phase = 1;
      r_bus = (pwr_word[1:0] == 2'd3) ? 4 : int'(pwr_word[1:0]) + 2;
      r_mem = dec_mem(int'(var_sel), mem_word);
      r_sta = dec_sta(int'(var_sel), sta_word);
      e_bus = 0; e_per = 0; e_mem = 0; e_sta = 0;
    end else begin
      phase = 2;
      e_bus = 0; e_per = 0; e_mem = 0; e_sta = 0;
      if (core_en) begin
        c_bus++;
        if (c_bus == r_bus) begin c_bus = 0; e_bus = 1; end
      end
      if (e_bus == 1) begin
        c_per++;
        if (c_per == 2) begin c_per = 0; e_per = 1; end
        c_mem++;
        if (c_mem == r_mem) begin c_mem = 0; e_mem = 1; end
      end
      if (e_per == 1) begin
        c_sta++;
        if (c_sta == r_sta) begin c_sta = 0; e_sta = 1; end
      end
    end
  end

  task automatic chk(input string tag, input string nm, input logic act, input int exp);
    total++;
    if (act !== exp[0]) begin
      bad++;
      $display("FAIL %s %s act=%0b exp=%0d t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (phase < 2) begin
        chk("R1", "bus_stb", bus_stb, e_bus);
        chk("R1", "per_stb", per_stb, e_per);
        chk("R1", "mem_stb", mem_stb, e_mem);
        chk("R1", "sta_stb", sta_stb, e_sta);
      end else begin
        chk(tg_bus, "bus_stb", bus_stb, e_bus);
        chk(tg_per, "per_stb", per_stb, e_per);
        chk(tg_mem, "mem_stb", mem_stb, e_mem);
        chk(tg_sta, "sta_stb", sta_stb, e_sta);
        chk("R10", "child_without_parent",
            (per_stb & ~bus_stb) | (mem_stb & ~bus_stb) | (sta_stb & ~per_stb), 0);
      end
    end
  end

  task automatic run_case(input logic [1:0] v, input logic [31:0] pw, input logic [31:0] mw,
                          input logic [31:0] sw, input bit rnd, input bit chg,
                          input string t_bus, input string t_mem, input string t_sta);
    @(negedge clk);
    rst = 1'b1; core_en = 1'b0;
    var_sel = v; pwr_word = pw; mem_word = mw; sta_word = sw;
    tg_bus = t_bus; tg_per = "R4"; tg_mem = t_mem; tg_sta = t_sta;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 300; i++) begin
      core_en = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
      if (chg && i == 120) begin
        // R9: configuration changes after capture must not matter
        var_sel = ~v; pwr_word = ~pw; mem_word = ~mw; sta_word = ~sw;
        tg_bus = "R9"; tg_per = "R9"; tg_mem = "R9"; tg_sta = "R9";
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    run_case(2'd0, 32'd0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "R2", "R6", "R7");
    run_case(2'd0, 32'd1, 32'h8000_8000, 32'h0000_0800, 1'b1, 1'b0, "R2", "R6", "R7");
    run_case(2'd1, 32'd2, 32'h8000_8000, 32'h0000_4000, 1'b0, 1'b1, "R2", "R6", "R8");
    run_case(2'd2, 32'd3, 32'h0000_8000, 32'h0000_E000, 1'b1, 1'b0, "R3", "R5", "R8");
    run_case(2'd3, 32'd0, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0, "R2", "R5", "R8");
    run_case(2'd2, 32'd1, 32'h8000_0000, 32'h0000_A000, 1'b0, 1'b0, "R2", "R5", "R8");
    run_case(2'd3, 32'd3, 32'h0000_8000, 32'h0000_2800, 1'b0, 1'b0, "R3", "R5", "R8");
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule